// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block runs ahead of an execution unit and fetches instruction bytes into a small queue of up to six entries. Each fetch address is a 20-bit physical address made from a 16-bit code segment and a 16-bit instruction offset. Requests go out on a simple memory port that is 8 or 16 bits wide, a choice fixed at build time. The fetcher refills the queue on its own whenever there is room. The consumer takes bytes one at a time through a valid/ready handshake, so memory traffic and consumption run independently.

When a branch occurs, the consumer raises `flush` together with the new segment and offset. The queue is emptied in that cycle. If a fetch is still waiting for memory, its data is dropped when it arrives, and fetching restarts at the new location.

The controller has three states. `FS_IDLE` waits for queue space. `FS_FETCH` holds a request until memory acknowledges it. `FS_DISCARD` waits out a request that a flush made stale. The transitions are:
- idle to fetch: no flush, and enough free entries;
- fetch to idle: acknowledge, with the data accepted, or discarded if a flush arrives in the same cycle;
- fetch to discard: flush without an acknowledge;
- discard to idle: acknowledge, with the data thrown away.

A flush seen in `FS_IDLE` keeps the controller idle for that cycle.

Top module: `seg_prefetch`

## Requirements
- R1: After reset, `out_valid` and `mem_req` are low, and the first bytes delivered come from segment RESET_SEG and offset RESET_OFF (by default FFFFh:0000h, which is physical FFFF0h).
- R2: The physical fetch address is (segment × 16 + offset) mod 2^20.
- R3: The queue never holds more than 6 bytes. A fetch starts only when at least 2 entries are free on a 16-bit port, or at least 1 on an 8-bit port. With the consumer stalled after a flush, a 16-bit port makes exactly 3 fetches (from an even or an odd start) and an 8-bit port makes exactly 6.
- R4: Bytes are delivered in order of increasing offset, one per cycle in which `out_valid` and `out_ready` are both high. A byte that is offered but not taken stays on `out_byte` in the next cycle unless a flush occurs.
- R5: On a 16-bit port with an even offset, `mem_rdata[7:0]` holds the byte at the even address and is queued first. `mem_rdata[15:8]` holds the byte at the next address and is queued second. The offset then advances by 2.
- R6: On a 16-bit port with an odd offset, only `mem_rdata[15:8]` is queued, and the offset advances by 1 to the next even value.
- R7: On an 8-bit port, `mem_rdata[7:0]` is queued and the offset advances by 1.
- R8: The offset wraps modulo 2^16 and the segment does not change.
- R9: When `flush` is high, `out_valid` is low in that cycle and in the next one. Delivery then resumes from the new segment and offset.
- R10: Data returned by a fetch that was outstanding at, or acknowledged during, a flush is never queued.
- R11: `out_valid` is low whenever the queue is empty.
- R12: Once `mem_req` is high, it and `mem_addr` stay unchanged until a cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue and restart fetching at `flush_seg`:`flush_off` |
| flush_seg | input | 16 | New code segment |
| flush_off | input | 16 | New instruction offset |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | 20 | Physical byte address of the fetch |
| mem_ack | input | 1 | Memory completes the request in this cycle |
| mem_rdata | input | BUS_W | Fetched data: byte lane 0 is the even address |
| out_valid | output | 1 | `out_byte` holds the next instruction byte |
| out_byte | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Consumer takes `out_byte` in this cycle |

## Verification
The bench builds two copies side by side, one with BUS_W = 16 and one with BUS_W = 8, and drives both with the same flush and ready stimulus. The 16-bit copy covers split lanes, odd-start alignment and the two-entry space threshold. The 8-bit copy covers single-byte stepping and filling all six entries. Long memory latencies make flushes during an outstanding fetch possible. Start offsets near FFFFh and segments near FFFFh drive both the 16-bit and the 20-bit wrap.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FETCH,
        FS_DISCARD
    } fetch_state_t;
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int PHYS_W = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [PHYS_W-1:0] phys
);
    localparam int BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base;

    assign base = {seg, {SHIFT{1'b0}}};
    // truncation to PHYS_W bits gives the modulo wrap
    assign phys = PHYS_W'(base) + PHYS_W'(off);
endmodule

// File: rtl/pf_byte_queue.sv
module pf_byte_queue #(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_d0,
    input  logic [7:0]       push_d1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= step_ptr(rd_ptr);
            unique case (push_n)
                2'd1:    wr_ptr <= step_ptr(wr_ptr);
                2'd2:    wr_ptr <= step_ptr(step_ptr(wr_ptr));
                default: wr_ptr <= wr_ptr;
            endcase
            count <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!clr) begin
                    if (push_n != 2'd0 && wr_ptr == PTR_W'(i))
                        slots[i] <= push_d0;
                    else if (push_n == 2'd2 && step_ptr(wr_ptr) == PTR_W'(i))
                        slots[i] <= push_d1;
                end
            end
        end
    endgenerate

    assign head = slots[rd_ptr];

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0 && !clr) |-> (32'(push_n) <= DEPTH - 32'(count)));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/pf_fetch_ctl.sv
module pf_fetch_ctl
    import pf_pkg::*;
#(
    parameter int          BUS_W     = 16,
    parameter int          SEG_W     = 16,
    parameter int          OFF_W     = 16,
    parameter int          PHYS_W    = 20,
    parameter int          DEPTH     = 6,
    parameter int          CNT_W     = $clog2(DEPTH + 1),
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_seg,
    input  logic [OFF_W-1:0]  flush_off,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic [CNT_W-1:0]  q_count,
    output logic [1:0]        push_n,
    output logic [7:0]        push_d0,
    output logic [7:0]        push_d1
);
    localparam int  NEED = BUS_W / 8;
    localparam bit  WIDE = (BUS_W == 16);

    fetch_state_t      state, nxt;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    logic [PHYS_W-1:0] phys, fetch_addr;
    logic              fetch_odd;
    logic              accept, start;
    logic [1:0]        lane_n;
    logic [OFF_W-1:0]  step;
    int                free_n;

    pf_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(4), .PHYS_W(PHYS_W)) u_addr (
        .seg (seg_q),
        .off (off_q),
        .phys(phys)
    );

    assign free_n = DEPTH - 32'(q_count);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:    if (!flush && free_n >= NEED) nxt = FS_FETCH;
            FS_FETCH:   if (mem_ack) nxt = FS_IDLE;
                        else if (flush) nxt = FS_DISCARD;
            FS_DISCARD: if (mem_ack) nxt = FS_IDLE;
            default:    nxt = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = (state != FS_IDLE);
        start   = (state == FS_IDLE) && (nxt == FS_FETCH);
        accept  = (state == FS_FETCH) && mem_ack && !flush;
        push_n  = accept ? lane_n : 2'd0;
        step    = (WIDE && !fetch_odd) ? OFF_W'(2) : OFF_W'(1);
    end

    assign mem_addr = fetch_addr;

    generate
        if (BUS_W == 16) begin : g_wide
            assign push_d0 = fetch_odd ? mem_rdata[BUS_W-1 -: 8] : mem_rdata[7:0];
            assign push_d1 = mem_rdata[BUS_W-1 -: 8];
            assign lane_n  = fetch_odd ? 2'd1 : 2'd2;
        end else begin : g_narrow
            assign push_d0 = mem_rdata[7:0];
            assign push_d1 = mem_rdata[7:0];
            assign lane_n  = 2'd1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q      <= SEG_W'(RESET_SEG);
            off_q      <= OFF_W'(RESET_OFF);
            fetch_addr <= '0;
            fetch_odd  <= 1'b0;
        end else begin
            if (flush) begin
                seg_q <= flush_seg;
                off_q <= flush_off;
            end else if (accept) begin
                off_q <= off_q + step;
            end
            if (start) begin
                fetch_addr <= phys;
                fetch_odd  <= off_q[0];
            end
        end
    end

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (push_n == 2'd0));

    p_space_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (free_n >= NEED));
endmodule

// File: rtl/seg_prefetch.sv
module seg_prefetch #(
    parameter int          BUS_W     = 16,
    parameter int          DEPTH     = 6,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [15:0]      flush_seg,
    input  logic [15:0]      flush_off,
    output logic             mem_req,
    output logic [19:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [BUS_W-1:0] mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    input  logic             out_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] q_count;
    logic [1:0]       push_n;
    logic [7:0]       push_d0, push_d1, head;
    logic             pop;

    pf_fetch_ctl #(
        .BUS_W(BUS_W), .SEG_W(16), .OFF_W(16), .PHYS_W(20),
        .DEPTH(DEPTH), .CNT_W(CNT_W),
        .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .flush_seg(flush_seg),
        .flush_off(flush_off),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .q_count  (q_count),
        .push_n   (push_n),
        .push_d0  (push_d0),
        .push_d1  (push_d1)
    );

    pf_byte_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flush),
        .push_n (push_n),
        .push_d0(push_d0),
        .push_d1(push_d1),
        .pop    (pop),
        .head   (head),
        .count  (q_count)
    );

    assign out_valid = (q_count != '0) && !flush;
    assign out_byte  = head;
    assign pop       = out_valid && out_ready;

    p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_byte))));
endmodule

// File: tb/seg_prefetch_test.sv
`timescale 1ns/1ps

module pf_mem_model #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             req,
    input  logic [19:0]      addr,
    output logic             ack,
    output logic [BUS_W-1:0] rdata,
    input  int               lat,
    output int               acks
);
    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] + 8'(a[15:8] * 3) + 8'(a[19:16] * 37);
    endfunction

    initial begin
        int          cnt;
        logic [19:0] base;
        logic [15:0] w;
        cnt = 0; ack = 1'b0; rdata = '0; acks = 0;
        forever begin
            @(posedge clk);
            #1;
            if (req && !ack) begin
                if (cnt >= lat) begin
                    base = (BUS_W == 16) ? {addr[19:1], 1'b0} : addr;
                    w = (BUS_W == 16) ? {mb(base + 20'd1), mb(base)} : {8'h00, mb(base)};
                    rdata = w[BUS_W-1:0];
                    ack = 1'b1;
                    acks++;
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end else begin
                ack = 1'b0;
                if (!req) cnt = 0;
            end
        end
    end
endmodule

module seg_prefetch_test;
    logic        clk = 1'b0;
    logic        rst_n, flush, rdy;
    logic [15:0] fl_seg, fl_off;
    int          lat;

    logic        req_a, ack_a, v_a;
    logic [19:0] addr_a;
    logic [15:0] rd_a;
    logic [7:0]  o_a;
    int          acks_a;

    logic        req_b, ack_b, v_b;
    logic [19:0] addr_b;
    logic [7:0]  rd_b;
    logic [7:0]  o_b;
    int          acks_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    seg_prefetch #(.BUS_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(fl_seg), .flush_off(fl_off),
        .mem_req(req_a), .mem_addr(addr_a), .mem_ack(ack_a), .mem_rdata(rd_a),
        .out_valid(v_a), .out_byte(o_a), .out_ready(rdy)
    );
    seg_prefetch #(.BUS_W(8)) uut8 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(fl_seg), .flush_off(fl_off),
        .mem_req(req_b), .mem_addr(addr_b), .mem_ack(ack_b), .mem_rdata(rd_b),
        .out_valid(v_b), .out_byte(o_b), .out_ready(rdy)
    );
    pf_mem_model #(.BUS_W(16)) mem_a (.clk(clk), .req(req_a), .addr(addr_a), .ack(ack_a),
                                      .rdata(rd_a), .lat(lat), .acks(acks_a));
    pf_mem_model #(.BUS_W(8))  mem_b (.clk(clk), .req(req_b), .addr(addr_b), .ack(ack_b),
                                      .rdata(rd_b), .lat(lat), .acks(acks_b));

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] + 8'(a[15:8] * 3) + 8'(a[19:16] * 37);
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return 20'({s, 4'h0}) + 20'(o);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // consumer-side reference streams
    logic [15:0] ex_seg_a, ex_off_a, ex_seg_b, ex_off_b;
    int got_a = 0, got_b = 0;

    initial begin
        ex_seg_a = 16'hFFFF; ex_off_a = 16'h0000;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ex_seg_a = 16'hFFFF; ex_off_a = 16'h0000;
            end else if (flush) begin
                ex_seg_a = fl_seg; ex_off_a = fl_off;
            end else if (v_a && rdy) begin
                // R2 R4 R5 R6 R8 R10: 16-bit stream follows byte addresses
                chk(o_a == mb(phys(ex_seg_a, ex_off_a)), "R2 R4 R5 R6 R8 R10 wide byte",
                    o_a, mb(phys(ex_seg_a, ex_off_a)));
                ex_off_a = ex_off_a + 16'd1;
                got_a++;
            end
        end
    end

    initial begin
        ex_seg_b = 16'hFFFF; ex_off_b = 16'h0000;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ex_seg_b = 16'hFFFF; ex_off_b = 16'h0000;
            end else if (flush) begin
                ex_seg_b = fl_seg; ex_off_b = fl_off;
            end else if (v_b && rdy) begin
                // R2 R4 R7 R8 R10: 8-bit stream
                chk(o_b == mb(phys(ex_seg_b, ex_off_b)), "R2 R4 R7 R8 R10 narrow byte",
                    o_b, mb(phys(ex_seg_b, ex_off_b)));
                ex_off_b = ex_off_b + 16'd1;
                got_b++;
            end
        end
    end

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(posedge clk); #1;
        flush = 1'b1; fl_seg = s; fl_off = o;
        @(negedge clk);
        chk(!v_a && !v_b, "R9 valid low in flush cycle", {v_a, v_b}, 0);
        @(posedge clk); #1;
        flush = 1'b0;
        @(negedge clk);
        chk(!v_a && !v_b, "R9 R11 queue empty after flush", {v_a, v_b}, 0);
    endtask

    task automatic run(input int cyc, input int mode);
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); #1;
            unique case (mode)
                0:       rdy = 1'b1;
                1:       rdy = (i % 2) == 0;
                default: rdy = (i % 3) != 0;
            endcase
        end
        @(posedge clk); #1;
        rdy = 1'b0;
    endtask

    // seg, off, lat, ready mode, cycles
    localparam logic [47:0] VEC [6] = '{
        {16'h1234, 16'h0000, 4'd0, 4'd0, 8'd60},
        {16'h1234, 16'h0001, 4'd1, 4'd1, 8'd80},
        {16'hF000, 16'hFFFC, 4'd0, 4'd0, 8'd60},
        {16'hFFFF, 16'hFFF0, 4'd2, 4'd2, 8'd90},
        {16'h0000, 16'h7FFF, 4'd3, 4'd1, 8'd90},
        {16'hABCD, 16'hFFFF, 4'd0, 4'd2, 8'd60}
    };

    initial begin
        int a0, b0;
        logic [19:0] held;
        rst_n = 1'b0; flush = 1'b0; rdy = 1'b0; fl_seg = '0; fl_off = '0; lat = 0;
        repeat (3) @(negedge clk);
        chk(!v_a && !v_b, "R1 out_valid low in reset", {v_a, v_b}, 0);
        chk(!req_a && !req_b, "R1 mem_req low in reset", {req_a, req_b}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: reset stream from FFFF:0000 checked by the monitors
        a0 = got_a; b0 = got_b;
        run(40, 0);
        chk(got_a > a0 && got_b > b0, "R1 delivery from reset address", got_a - a0, 1);

        foreach (VEC[k]) begin
            lat = int'(VEC[k][15:12]);
            do_flush(VEC[k][47:32], VEC[k][31:16]);
            a0 = got_a; b0 = got_b;
            run(int'(VEC[k][7:0]), int'(VEC[k][11:8]));
            chk(got_a - a0 >= 8, "R4 wide progress", got_a - a0, 8);
            chk(got_b - b0 >= 8, "R4 narrow progress", got_b - b0, 8);
        end

        // R3: stalled consumer, even start
        lat = 0;
        do_flush(16'h2000, 16'h0000);
        a0 = acks_a; b0 = acks_b;
        repeat (40) @(negedge clk);
        chk(acks_a - a0 == 3, "R3 wide fetches even start", acks_a - a0, 3);
        chk(acks_b - b0 == 6, "R3 narrow fetches", acks_b - b0, 6);
        chk(!req_a && !req_b, "R3 no request when full", {req_a, req_b}, 0);
        chk(v_a && v_b, "R11 valid with data", {v_a, v_b}, 3);
        run(30, 0);

        // R3 R6: stalled consumer, odd start leaves one entry free
        do_flush(16'h2000, 16'h0001);
        a0 = acks_a;
        repeat (40) @(negedge clk);
        chk(acks_a - a0 == 3, "R3 R6 wide fetches odd start", acks_a - a0, 3);
        chk(!req_a, "R3 no request with one free entry", req_a, 0);
        run(30, 1);

        // R12 R10: flush while a slow fetch is outstanding
        lat = 5;
        do_flush(16'h3000, 16'h0010);
        while (!req_a) @(negedge clk);
        held = addr_a;
        @(negedge clk);
        chk(req_a && addr_a == held, "R12 request and address held", addr_a, held);
        @(negedge clk);
        chk(req_a && addr_a == held, "R12 request held again", addr_a, held);
        do_flush(16'h4000, 16'h0020);
        do_flush(16'h5000, 16'h0003);
        a0 = got_a; b0 = got_b;
        run(120, 0);
        chk(got_a - a0 >= 8, "R10 wide delivery after stale drop", got_a - a0, 8);
        chk(got_b - b0 >= 8, "R10 narrow delivery after stale drop", got_b - b0, 8);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule